// File: doc/BRIEF.md
# Dual-Space I2C Target Controller

This block is an I2C target that puts two separate register spaces behind one bus port. A memory space, which also holds configuration data, answers to one 4-bit device-type code. A command space answers to a second code. SCL and SDA are sampled by a fast system clock. Each line passes through a two-flop synchronizer and a glitch filter. The block finds start and stop conditions, decodes the address byte against a device address built from configuration inputs and one optional pin, and drives an open-drain enable on SDA.

A write sets a byte pointer and then stores data bytes. For the memory space, the data bytes are collected in a 16-byte page buffer. They are copied into the array, together with a one-cycle commit strobe, only when a stop ends the transaction cleanly. A write that is cut off by a repeated start only leaves the pointer set, which is how a host prepares a random read. Reads stream bytes from the pointer onward for as long as the host acknowledges. A monitor-halt output is high from the address acknowledge until the stop.

Top module: `i2c_dual_space_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe`=0), `monitor_halt` is low, and every byte of both spaces reads back as 0x00.
- R2: The address byte is bits [7:4] device type, bits [3:1] device address, bit [0] direction (1 = read). The device type is 1010 for the memory space, or 1011 when `cfg_mem_alt`=1, and 1001 for the command space. The device address must equal {`cfg_a2_sel` ? `a2_pin` : 0, `cfg_bus_addr`}. On a mismatch the block gives no acknowledge and ignores all further bytes until the next start.
- R3: Bytes are sent MSB first with a ninth acknowledge clock. The block only starts pulling SDA low while filtered SCL is low.
- R4: In a write, the first byte after the address sets the pointer. Each following data byte goes to the pointer and then increments only the low 4 bits of the pointer, so a write wraps inside its 16-byte page.
- R5: Memory-space data reaches the array only when a stop follows an acknowledged byte. Each such stop gives exactly one single-cycle `commit_pulse`.
- R6: A repeated start during a write commits nothing. The pointer keeps its value.
- R7: A read returns the byte at the pointer, then bytes from the following addresses across the whole space (8-bit pointer), for as long as the host acknowledges. After a host NACK the block stays silent until a start or stop.
- R8: Command-space data bytes take effect when each byte is acknowledged, with no stop needed.
- R9: `monitor_halt` rises together with the address acknowledge of a matching address byte. It stays high through repeated starts and falls after a stop.
- R10: A start or stop with two or more bits of a byte received aborts the transfer and throws away all uncommitted page data.
- R11: SCL pulses shorter than `FILT_LEN` system clocks have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| a2_pin | input | 1 | External level for device address bit 2 |
| cfg_a2_sel | input | 1 | 1: address bit 2 comes from `a2_pin`; 0: it must be 0 |
| cfg_bus_addr | input | 2 | Device address bits [1:0] |
| cfg_mem_alt | input | 1 | 1: memory space answers to type 1011 instead of 1010 |
| monitor_halt | output | 1 | High from address acknowledge until stop |
| commit_pulse | output | 1 | One-cycle strobe when page data is written to the array |

## Verification
The hardest state to reach is a page buffer that holds acknowledged data at the moment the transaction ends without a clean stop. One way is a repeated start after a data byte. The other is a stop issued half-way through the following byte. The bench reaches both by driving the bus at bit level. It can halt inside a byte after four bits and then issue the stop. Reading back the same page shows whether anything leaked into the array, and the strobe count is compared as well. SCL glitches that are narrower than the filter are injected in the middle of a high phase while a write is in progress.

// File: rtl/i2cd_pkg.sv
// Shared constants and types for the dual-space I2C target.
package i2cd_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,   // not addressed, waiting for start
        PH_ADDR,   // receiving the address byte
        PH_PTR,    // receiving the pointer byte
        PH_WDATA,  // receiving data bytes
        PH_RDATA   // sending data bytes
    } phase_t;

    localparam logic [3:0] TYPE_MEM     = 4'b1010;
    localparam logic [3:0] TYPE_MEM_ALT = 4'b1011;
    localparam logic [3:0] TYPE_CMD     = 4'b1001;
    localparam int         PAGE_BITS    = 4;
endpackage

// File: rtl/i2cd_line_filter.sv
// Two-flop synchronizer followed by a stability filter.
// Assumes: raw is asynchronous; the output only changes after the synchronized
// level has differed from it for FILT_LEN consecutive clocks.
module i2cd_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Synchronize, then accept a new level only after it has been stable long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            clean  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == clean) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                clean <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2cd_bus_events.sv
// Edge and condition detector on the filtered bus lines.
// Assumes: inputs are already synchronous; outputs are single-cycle pulses.
module i2cd_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, sda_q;

    // Remember last-cycle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // SDA moving while SCL stays high marks start/stop.
    always_comb begin
        scl_rise = scl && !scl_q;
        scl_fall = !scl && scl_q;
        start_ev = scl && scl_q && sda_q && !sda;
        stop_ev  = scl && scl_q && !sda_q && sda;
    end
endmodule

// File: rtl/i2cd_page_store.sv
// Storage for both spaces plus the page buffer for memory writes.
// Assumes: commit_req has priority over buf_clr and buf_we; the commit writes
// every buffered entry into the page last written and pulses commit_pulse.
module i2cd_page_store #(
    parameter int MEM_AW = 8,
    parameter int CMD_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we,
    input  logic [3:0]        buf_idx,
    input  logic [MEM_AW-5:0] buf_page,
    input  logic [7:0]        buf_data,
    input  logic              buf_clr,
    input  logic              commit_req,
    input  logic              cmd_we,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              rd_cmd,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              commit_pulse
);
    localparam int MEM_DEPTH = 1 << MEM_AW;
    localparam int CMD_DEPTH = 1 << CMD_AW;
    localparam int PAGE_LEN  = 1 << i2cd_pkg::PAGE_BITS;

    logic [7:0]          mem_q  [MEM_DEPTH];
    logic [7:0]          cmd_q  [CMD_DEPTH];
    logic [7:0]          pbuf_q [PAGE_LEN];
    logic [PAGE_LEN-1:0] pvalid_q;
    logic [MEM_AW-5:0]   page_q;

    // Page buffer fill, commit into the array, and immediate command writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= 8'h00;
            for (int i = 0; i < CMD_DEPTH; i++) cmd_q[i] <= 8'h00;
            for (int i = 0; i < PAGE_LEN; i++)  pbuf_q[i] <= 8'h00;
            pvalid_q     <= '0;
            page_q       <= '0;
            commit_pulse <= 1'b0;
        end else begin
            commit_pulse <= 1'b0;
            if (commit_req && pvalid_q != '0) begin
                for (int i = 0; i < PAGE_LEN; i++)
                    if (pvalid_q[i]) mem_q[{page_q, 4'(i)}] <= pbuf_q[i];
                pvalid_q     <= '0;
                commit_pulse <= 1'b1;
            end else if (buf_clr || commit_req) begin
                pvalid_q <= '0;
            end else if (buf_we) begin
                pbuf_q[buf_idx]   <= buf_data;
                pvalid_q[buf_idx] <= 1'b1;
                page_q            <= buf_page;
            end
            if (cmd_we) cmd_q[cmd_addr] <= cmd_data;
        end
    end

    // Read port: committed contents only.
    always_comb rd_data = rd_cmd ? cmd_q[rd_addr[CMD_AW-1:0]] : mem_q[rd_addr];
endmodule

// File: rtl/i2c_dual_space_target.sv
// I2C target serving a memory space and a command space.
// Assumes: SCL period is many system clocks (each half longer than the
// filter latency); a single pointer is shared by both spaces.
module i2c_dual_space_target #(
    parameter int FILT_LEN = 4,
    parameter int MEM_AW   = 8,
    parameter int CMD_AW   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       a2_pin,
    input  logic       cfg_a2_sel,
    input  logic [1:0] cfg_bus_addr,
    input  logic       cfg_mem_alt,
    output logic       monitor_halt,
    output logic       commit_pulse
);
    import i2cd_pkg::*;
    localparam int PW = MEM_AW;

    logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;
    phase_t      phase_q;
    logic [3:0]  bitcnt_q;
    logic [7:0]  sh_q, tx_q, rd_data;
    logic [PW-1:0] ptr_q;
    logic rw_q, cmd_sel_q, ack_drv_q, tx_act_q, mack_q, halt_q;
    logic hit_type, addr_ok, rx_done, buf_we, cmd_we, commit_req, in_idle;

    i2cd_line_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw(scl_i), .clean(scl_f));
    i2cd_line_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw(sda_i), .clean(sda_f));
    i2cd_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev));

    // Address decode and storage control strobes.
    always_comb begin
        hit_type   = (sh_q[7:4] == (cfg_mem_alt ? TYPE_MEM_ALT : TYPE_MEM))
                   || (sh_q[7:4] == TYPE_CMD);
        addr_ok    = sh_q[3:1] == {cfg_a2_sel ? a2_pin : 1'b0, cfg_bus_addr};
        rx_done    = scl_fall && bitcnt_q == 4'd8 && phase_q == PH_WDATA;
        buf_we     = rx_done && !cmd_sel_q;
        cmd_we     = rx_done && cmd_sel_q;
        commit_req = stop_ev && phase_q == PH_WDATA && bitcnt_q <= 4'd1;
        in_idle    = phase_q == PH_IDLE;
    end

    i2cd_page_store #(.MEM_AW(MEM_AW), .CMD_AW(CMD_AW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .buf_we(buf_we), .buf_idx(ptr_q[3:0]), .buf_page(ptr_q[PW-1:4]),
        .buf_data(sh_q), .buf_clr(start_ev || stop_ev),
        .commit_req(commit_req),
        .cmd_we(cmd_we), .cmd_addr(ptr_q[CMD_AW-1:0]), .cmd_data(sh_q),
        .rd_cmd(cmd_sel_q), .rd_addr(ptr_q), .rd_data(rd_data),
        .commit_pulse(commit_pulse));

    // Byte-level protocol engine driven by filtered SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;  bitcnt_q <= '0;  sh_q <= '0;  tx_q <= '0;
            ptr_q <= '0;  rw_q <= 1'b0;  cmd_sel_q <= 1'b0;  ack_drv_q <= 1'b0;
            tx_act_q <= 1'b0;  mack_q <= 1'b0;  halt_q <= 1'b0;
        end else if (start_ev) begin
            phase_q <= PH_ADDR;  bitcnt_q <= '0;
            ack_drv_q <= 1'b0;   tx_act_q <= 1'b0;
        end else if (stop_ev) begin
            phase_q <= PH_IDLE;  bitcnt_q <= '0;
            ack_drv_q <= 1'b0;   tx_act_q <= 1'b0;  halt_q <= 1'b0;
        end else if (phase_q != PH_IDLE) begin
            if (scl_rise) begin
                if (bitcnt_q < 4'd8)  sh_q <= {sh_q[6:0], sda_f};
                if (bitcnt_q == 4'd8) mack_q <= !sda_f;
                if (bitcnt_q < 4'd9)  bitcnt_q <= bitcnt_q + 4'd1;
            end else if (scl_fall && phase_q == PH_RDATA) begin
                if (bitcnt_q >= 4'd1 && bitcnt_q <= 4'd7) begin
                    tx_q <= {tx_q[6:0], 1'b0};
                end else if (bitcnt_q == 4'd8) begin
                    tx_act_q <= 1'b0;
                end else if (bitcnt_q == 4'd9) begin
                    if (mack_q) begin
                        tx_q <= rd_data;  tx_act_q <= 1'b1;
                        ptr_q <= ptr_q + 1'b1;  bitcnt_q <= '0;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
            end else if (scl_fall && bitcnt_q == 4'd8) begin
                case (phase_q)
                    PH_ADDR: if (hit_type && addr_ok) begin
                        ack_drv_q <= 1'b1;  halt_q <= 1'b1;
                        cmd_sel_q <= (sh_q[7:4] == TYPE_CMD);  rw_q <= sh_q[0];
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                    PH_PTR:   begin ack_drv_q <= 1'b1;  ptr_q <= sh_q; end
                    PH_WDATA: begin
                        ack_drv_q <= 1'b1;
                        ptr_q <= {ptr_q[PW-1:4], 4'(ptr_q[3:0] + 4'd1)};
                    end
                    default: ;
                endcase
            end else if (scl_fall && bitcnt_q == 4'd9) begin
                ack_drv_q <= 1'b0;  bitcnt_q <= '0;
                if (phase_q == PH_ADDR && rw_q) begin
                    phase_q <= PH_RDATA;  tx_q <= rd_data;  tx_act_q <= 1'b1;
                    ptr_q <= ptr_q + 1'b1;
                end else if (phase_q == PH_ADDR) begin
                    phase_q <= PH_PTR;
                end else if (phase_q == PH_PTR) begin
                    phase_q <= PH_WDATA;
                end
            end
        end
    end

    // Open-drain drive: acknowledge slot or a zero data bit.
    always_comb begin
        sda_oe       = ack_drv_q || (tx_act_q && !tx_q[7]);
        monitor_halt = halt_q;
    end
endmodule

// File: rtl/i2cd_checker.sv
// Property checker for the dual-space I2C target, bound to the top.
// Assumes: sees the filtered SCL, the stop pulse and the idle state.
module i2cd_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic stop_ev,
    input logic in_idle,
    input logic sda_oe,
    input logic monitor_halt,
    input logic commit_pulse
);
    // R3: pull-down only begins while SCL is low
    p_drive_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);

    // R9: halt rises in the same cycle the acknowledge starts
    p_halt_with_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(monitor_halt) |-> sda_oe);

    // R9: a stop clears the halt
    p_halt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !monitor_halt);

    // R5: commit strobe only right after a stop
    p_commit_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |-> $past(stop_ev));

    // R5: commit strobe is one cycle wide
    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |=> !commit_pulse);

    // R2: an unaddressed target stays off the bus
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && $past(in_idle)) |-> !sda_oe);
endmodule

bind i2c_dual_space_target i2cd_checker u_i2cd_checker (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .stop_ev(stop_ev),
    .in_idle(in_idle), .sda_oe(sda_oe), .monitor_halt(monitor_halt),
    .commit_pulse(commit_pulse));

// File: tb/test_i2c_dual_space_target.sv
module test_i2c_dual_space_target;
    localparam int Q = 16;          // quarter SCL period in system clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       a2_pin = 1'b0, cfg_a2_sel = 1'b0, cfg_mem_alt = 1'b0;
    logic [1:0] cfg_bus_addr = 2'b01;
    logic       sda_oe, monitor_halt, commit_pulse;
    wire        sda_line = sda_m & ~sda_oe;

    i2c_dual_space_target i_i2c_dual_space_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .a2_pin(a2_pin), .cfg_a2_sel(cfg_a2_sel),
        .cfg_bus_addr(cfg_bus_addr), .cfg_mem_alt(cfg_mem_alt),
        .monitor_halt(monitor_halt), .commit_pulse(commit_pulse));

    int n_vec = 0, n_bad = 0;
    int settle = 0, commits = 0, exp_commits = 0;
    bit exp_halt = 1'b0;
    logic [7:0] mem_ref [0:255];
    logic [7:0] cmd_ref [0:15];
    logic [7:0] ptr_ref = 8'h00;
    logic [7:0] none [$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_halt(input bit v);
        exp_halt = v;
        settle   = 96;
    endtask

    // R9 reference: compare halt on every clock outside transition windows
    always @(negedge clk) begin
        if (rst_n) begin
            if (settle > 0) settle--;
            else chk("R9 monitor_halt", monitor_halt, exp_halt);
        end
    end

    always @(posedge clk) if (rst_n && commit_pulse) commits++;

    task automatic start_c();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic stop_c();
        set_halt(1'b0);
        scl_m = 1'b0; sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input bit b, input bit glitch);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(Q);
        if (glitch) begin scl_m = 1'b0; wq(2); scl_m = 1'b1; end
        wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output bit b);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        b = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output bit acked,
                              input int halt_to, input bit glitch);
        bit a;
        for (int i = 7; i >= 0; i--) begin
            if (i == 0 && halt_to >= 0) set_halt(halt_to[0]);
            send_bit(v[i], glitch);
        end
        recv_bit(a);
        acked = !a;
    endtask

    task automatic read_byte(output logic [7:0] v, input bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
        send_bit(!ack, 1'b0);
    endtask

    // Address + pointer + data; model updates memory only on a clean stop.
    task automatic xfer_write(input logic [7:0] dev, input logic [7:0] p,
                              input logic [7:0] d[$], input bit do_stop, input bit glitch);
        bit ak;
        bit is_cmd = (dev[7:4] == 4'h9);
        logic [7:0] pa[$], pd[$];
        logic [7:0] cur = p;
        start_c();
        write_byte(dev, ak, 1, glitch);  chk("R2 address ack", ak, 1);
        write_byte(p, ak, -1, glitch);   chk("R4 pointer ack", ak, 1);
        foreach (d[i]) begin
            write_byte(d[i], ak, -1, glitch); chk("R4 data ack", ak, 1);
            if (is_cmd) cmd_ref[cur[3:0]] = d[i];
            else begin pa.push_back(cur); pd.push_back(d[i]); end
            cur = {cur[7:4], 4'(cur[3:0] + 4'd1)};
        end
        ptr_ref = cur;
        if (do_stop) begin
            stop_c();
            foreach (pa[i]) mem_ref[pa[i]] = pd[i];
            if (pd.size() > 0) exp_commits++;
            chk("R5 commit count", commits, exp_commits);
        end
    endtask

    // Dummy write to p, repeated start, then n sequential reads.
    task automatic xfer_read(input logic [7:0] dev, input logic [7:0] p, input int n);
        bit ak;
        logic [7:0] v, e;
        bit is_cmd = (dev[7:4] == 4'h9);
        xfer_write(dev, p, none, 1'b0, 1'b0);
        start_c();
        write_byte(dev | 8'h01, ak, 1, 1'b0); chk("R2 read address ack", ak, 1);
        for (int i = 0; i < n; i++) begin
            read_byte(v, i != n - 1);
            e = is_cmd ? cmd_ref[ptr_ref[3:0]] : mem_ref[ptr_ref];
            chk("R7 read data", v, e);
            ptr_ref = ptr_ref + 8'd1;
        end
        stop_c();
    endtask

    task automatic expect_nack(input logic [7:0] dev, input string req);
        bit ak;
        start_c();
        write_byte(dev, ak, 0, 1'b0); chk(req, ak, 0);
        write_byte(8'h10, ak, -1, 1'b0); chk("R2 ignored after mismatch", ak, 0);
        stop_c();
    endtask

    initial begin
        bit ak;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) mem_ref[i] = 8'h00;
        for (int i = 0; i < 16; i++)  cmd_ref[i] = 8'h00;
        wq(10); rst_n = 1'b1; wq(20);
        chk("R1 sda released", sda_oe, 0);
        chk("R1 halt low", monitor_halt, 0);

        // R4 R5 R7: page write, then read including a never-written byte (R1)
        xfer_write(8'hA2, 8'h10, '{8'h11, 8'h22, 8'h33}, 1'b1, 1'b0);
        xfer_read(8'hA2, 8'h10, 4);

        // R4: wrap inside the page
        xfer_write(8'hA2, 8'h1E, '{8'h5A, 8'h6B, 8'h7C, 8'h8D, 8'h9E}, 1'b1, 1'b0);
        xfer_read(8'hA2, 8'h1E, 2);
        xfer_read(8'hA2, 8'h10, 3);

        // R7: sequential read crosses a page boundary
        xfer_write(8'hA2, 8'h2E, '{8'hC1, 8'hC2}, 1'b1, 1'b0);
        xfer_write(8'hA2, 8'h30, '{8'hC3}, 1'b1, 1'b0);
        xfer_read(8'hA2, 8'h2E, 3);

        // R6: data followed by a repeated start is dropped; halt held (R9)
        xfer_write(8'hA2, 8'h40, '{8'hE7}, 1'b0, 1'b0);
        start_c();
        write_byte(8'hA3, ak, 1, 1'b0); chk("R6 restart address ack", ak, 1);
        read_byte(v, 1'b0);
        chk("R6 pointer kept after restart", v, mem_ref[ptr_ref]);
        stop_c();
        chk("R6 no commit on restart", commits, exp_commits);
        xfer_read(8'hA2, 8'h40, 1);

        // R10: stop in the middle of a byte discards buffered data
        start_c();
        write_byte(8'hA2, ak, 1, 1'b0); chk("R10 address ack", ak, 1);
        write_byte(8'h50, ak, -1, 1'b0);
        write_byte(8'h77, ak, -1, 1'b0); chk("R10 data ack", ak, 1);
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        stop_c();
        chk("R10 no commit after abort", commits, exp_commits);
        xfer_read(8'hA2, 8'h50, 1);

        // R2: wrong device address is ignored
        expect_nack(8'hA6, "R2 wrong address nack");

        // R8: command space updates without a stop
        xfer_write(8'h92, 8'h03, '{8'hC3}, 1'b0, 1'b0);
        start_c();
        write_byte(8'h92, ak, 1, 1'b0);
        write_byte(8'h03, ak, -1, 1'b0);
        start_c();
        write_byte(8'h93, ak, 1, 1'b0); chk("R8 command read ack", ak, 1);
        read_byte(v, 1'b0); chk("R8 command data immediate", v, 8'hC3);
        stop_c();
        chk("R8 no commit for command space", commits, exp_commits);

        // R2: alternate memory type code
        cfg_mem_alt = 1'b1;
        expect_nack(8'hA2, "R2 primary type rejected in alt mode");
        xfer_read(8'hB2, 8'h10, 1);
        cfg_mem_alt = 1'b0;

        // R2: address bit 2 from pin
        cfg_a2_sel = 1'b1; a2_pin = 1'b1;
        expect_nack(8'hA2, "R2 pin bit mismatch");
        xfer_read(8'hAA, 8'h11, 1);
        a2_pin = 1'b0;
        xfer_read(8'hA2, 8'h12, 1);
        cfg_a2_sel = 1'b0;

        // R11: short SCL glitches inside high phases are filtered out
        xfer_write(8'hA2, 8'h60, '{8'h3C, 8'hA5}, 1'b1, 1'b1);
        xfer_read(8'hA2, 8'h60, 2);

        wq(50);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule